// File: doc/BRIEF.md
# Status Indicator Lamp Controller

This block is a single memory-mapped control word that drives four status indicator lamps. Each lamp has two controls. A steady-on bit lights the lamp continuously. A blink bit makes the lamp flash, using a timebase that the block generates itself. If both bits are set, the steady-on bit wins.

The first three lamps also have a toggle mode. While the toggle mode of a lamp is selected, writing a 1 to its steady-on bit flips the stored bit instead of loading it. Software can then flip a lamp without first reading the register back.

A separate mode bit makes lamp 1 copy an external carrier-detect level. In that mode the lamp ignores both of its own control bits. Writes and reads each take a single cycle. A read returns the stored control bits and does not return the lamp levels.

Top module: `ledCtrlReg`

## Requirements
- R1: After reset every stored control bit is 0, `rdData` reads 0 and all four lamp outputs are 0.
- R2: Word bits 16, 17, 18 and 19 are the steady-on controls of lamps 1, 2, 3 and 4. A stored 1 holds the matching output at 1 in every cycle.
- R3: Word bits 20, 21, 22 and 23 are the blink controls of lamps 1, 2, 3 and 4.
  - A lamp that has only its blink bit set follows a shared blink phase.
  - Once reset is released, the phase after k rising clock edges is floor(k / HALF_PERIOD) mod 2. It starts at 0, has a 50 percent duty cycle and has a period of 2*HALF_PERIOD cycles.
- R4: When the steady-on bit and the blink bit of a lamp are both 1, the output stays at 1 whatever the blink phase.
- R5: Word bits 24, 25 and 26 select toggle mode for lamps 1, 2 and 3. Toggle mode is taken from the same written word.
  - In toggle mode, writing 1 to the steady-on bit inverts the stored bit.
  - In toggle mode, writing 0 to the steady-on bit leaves the stored bit unchanged.
- R6: Lamp 4 has no toggle mode. Its steady-on bit always takes the written value.
- R7: Word bit 13 selects carrier mode. While the stored bit is 1, lamp output 1 equals `carrierIn`, overriding both the steady-on and blink bits of lamp 1. The other lamps are unaffected.
- R8: `rdData` returns the stored bits at the positions they were written, including on bits that were inverted. All other bits read 0. The value reflects stored state, not lamp levels.
- R9: In a cycle without `wrEn`, no stored control bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe; `wrData` is taken at the rising edge |
| wrData | input | DATA_W | Write data word |
| rdData | output | DATA_W | Stored control bits |
| carrierIn | input | 1 | External carrier-detect level |
| ledOut | output | 4 | Lamp drive levels, bit 0 is lamp 1 |

## Verification
The hardest case to reach is the interaction of a blink bit with the shared phase. A blink bit set at an arbitrary point must show its level in the correct cycle, across a phase flip. The bench sweeps all 256 combinations of steady-on and blink bits. After each write it checks every lamp over a full blink period, predicting the phase from its own count of edges since reset. Toggle behaviour is driven by a sequence of writes that both invert and retain bits, with lamp 4 alongside as a direct-write contrast.

// File: rtl/ledCtrlPkg.sv
package ledCtrlPkg;
  localparam int NUM_LED   = 4;
  localparam int NUM_TGL   = 3;
  localparam int ON_LSB    = 16;
  localparam int FLASH_LSB = 20;
  localparam int TGL_LSB   = 24;
  localparam int CD_BIT    = 13;
  localparam int MIN_W     = TGL_LSB + NUM_TGL;

  typedef struct packed {
    logic               load;
    logic [NUM_LED-1:0] onData;
    logic [NUM_LED-1:0] tglMask;
    logic [NUM_LED-1:0] flashData;
    logic               cdData;
    logic               flashPhase;
  } ledStrobe_t;
endpackage

// File: rtl/ledCtrlCtl.sv
module ledCtrlCtl
  import ledCtrlPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int HALF_PERIOD = 12_500_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output ledStrobe_t        strobe
);
  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0]   divCnt;
  logic               phase;
  logic [NUM_LED-1:0] tglMask;

  // Free-running blink timebase shared by all lamps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (divCnt == CNT_LAST) begin
      divCnt <= '0;
      phase  <= ~phase;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Only the lower lamps have a toggle mode
  for (genvar i = 0; i < NUM_LED; i++) begin : gTgl
    if (i < NUM_TGL) begin : gHas
      assign tglMask[i] = wrData[TGL_LSB+i];
    end else begin : gNone
      assign tglMask[i] = 1'b0;
    end
  end

  always_comb begin
    strobe.load       = wrEn;
    strobe.onData     = wrData[ON_LSB +: NUM_LED];
    strobe.flashData  = wrData[FLASH_LSB +: NUM_LED];
    strobe.tglMask    = tglMask;
    strobe.cdData     = wrData[CD_BIT];
    strobe.flashPhase = phase;
  end

  AST_PHASE_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(phase) |-> $past(divCnt) == CNT_LAST) else $error("phase flip off wrap"); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= CNT_LAST) else $error("divider out of range"); // R3
endmodule

// File: rtl/ledCtrlDp.sv
module ledCtrlDp
  import ledCtrlPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ledStrobe_t         strobe,
  input  logic               carrierIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_LED-1:0] ledOut
);
  logic [NUM_LED-1:0] onReg;
  logic [NUM_LED-1:0] flashReg;
  logic [NUM_TGL-1:0] tglReg;
  logic               cdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onReg    <= '0;
      flashReg <= '0;
      tglReg   <= '0;
      cdReg    <= 1'b0;
    end else if (strobe.load) begin
      for (int i = 0; i < NUM_LED; i++) begin
        if (strobe.tglMask[i]) begin
          if (strobe.onData[i]) onReg[i] <= ~onReg[i];
        end else begin
          onReg[i] <= strobe.onData[i];
        end
      end
      flashReg <= strobe.flashData;
      tglReg   <= strobe.tglMask[NUM_TGL-1:0];
      cdReg    <= strobe.cdData;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[ON_LSB +: NUM_LED]    = onReg;
    rdData[FLASH_LSB +: NUM_LED] = flashReg;
    rdData[TGL_LSB +: NUM_TGL]   = tglReg;
    rdData[CD_BIT]               = cdReg;
  end

  for (genvar i = 0; i < NUM_LED; i++) begin : gLed
    if (i == 0) begin : gCarrier
      assign ledOut[i] = cdReg ? carrierIn
                       : (onReg[i] | (flashReg[i] & strobe.flashPhase));
    end else begin : gPlain
      assign ledOut[i] = onReg[i] | (flashReg[i] & strobe.flashPhase);
    end

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobe.load && strobe.tglMask[i] && strobe.onData[i])
      |-> onReg[i] != $past(onReg[i])) else $error("toggle failed"); // R5
    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobe.load && strobe.tglMask[i] && !strobe.onData[i])
      |-> $stable(onReg[i])) else $error("toggle hold failed"); // R5
  end

  AST_ON_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (onReg[1] && flashReg[1]) |-> ledOut[1]) else $error("on lost to flash"); // R4
  AST_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    cdReg |-> ledOut[0] == carrierIn) else $error("carrier not followed"); // R7
  AST_LED4_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load) |-> onReg[NUM_LED-1] == $past(strobe.onData[NUM_LED-1]))
    else $error("lamp 4 not direct"); // R6
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.load) |-> $stable(rdData)) else $error("state moved"); // R9
endmodule

// File: rtl/ledCtrlReg.sv
module ledCtrlReg
  import ledCtrlPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int HALF_PERIOD = 12_500_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              carrierIn,
  output logic [3:0]        ledOut
);
  ledStrobe_t strobe;

  initial begin
    AST_WIDTH_OK: assert (DATA_W >= MIN_W) else $error("DATA_W too small"); // R8
  end

  ledCtrlCtl #(.DATA_W(DATA_W), .HALF_PERIOD(HALF_PERIOD)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .strobe(strobe)
  );

  ledCtrlDp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .carrierIn(carrierIn),
    .rdData(rdData), .ledOut(ledOut)
  );
endmodule

// File: tb/ledCtrlReg_test.sv
`timescale 1ns/1ps
module ledCtrlReg_test;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        carrierIn = 1'b0;
  logic [3:0]  ledOut;

  int checks = 0;
  int errors = 0;
  int edges = 0;

  ledCtrlReg #(.DATA_W(32), .HALF_PERIOD(H)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .carrierIn(carrierIn), .ledOut(ledOut)
  );

  always #2 clk = ~clk;
  always @(posedge clk) if (rstN) edges <= edges + 1;

  function automatic logic phaseNow();
    return ((edges / H) % 2) == 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  function automatic logic [31:0] word(logic [3:0] on, logic [3:0] fl,
                                       logic [2:0] tg, logic cd);
    return (32'(on) << 16) | (32'(fl) << 20) | (32'(tg) << 24) | (32'(cd) << 13);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd in reset", rdData, 32'h0);
    chk("R1 led in reset", 32'(ledOut), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rd after reset", rdData, 32'h0);
    chk("R1 led after reset", 32'(ledOut), 32'h0);

    // R2 R3 R4 sweep of every on/blink combination over a full period
    for (int v = 0; v < 256; v++) begin
      logic [3:0] on, fl;
      on = v[3:0];
      fl = v[7:4];
      wr(word(on, fl, 3'b000, 1'b0));
      chk("R8 readback", rdData, word(on, fl, 3'b000, 1'b0));
      for (int k = 0; k < 2 * H; k++) begin
        logic [3:0] exp;
        exp = on | (fl & {4{phaseNow()}});
        chk("R2/R3/R4 lamps", 32'(ledOut), 32'(exp));
        @(negedge clk);
      end
      chk("R9 hold", rdData, word(on, fl, 3'b000, 1'b0));
    end

    // R5 R6 toggle sequence
    wr(32'h0);
    wr(word(4'hF, 4'h0, 3'b111, 1'b0));
    chk("R5 invert to 1", 32'(ledOut), 32'hF);
    wr(word(4'h0, 4'h0, 3'b111, 1'b0));
    chk("R5 hold / R6 direct", 32'(ledOut), 32'h7);
    chk("R8 readback toggled", rdData, word(4'h7, 4'h0, 3'b111, 1'b0));
    wr(word(4'h5, 4'h0, 3'b111, 1'b0));
    chk("R5 invert to 0", 32'(ledOut), 32'h2);
    wr(word(4'h8, 4'h0, 3'b111, 1'b0));
    chk("R6 lamp 4 set", 32'(ledOut), 32'hA);
    wr(word(4'h8, 4'h0, 3'b111, 1'b0));
    chk("R6 lamp 4 no toggle", 32'(ledOut), 32'hA);
    wr(word(4'h0, 4'h0, 3'b000, 1'b0));
    chk("R5 direct when off", 32'(ledOut), 32'h0);

    // R7 carrier mode
    wr(word(4'h3, 4'h1, 3'b000, 1'b1));
    for (int k = 0; k < 2 * H; k++) begin
      carrierIn = k[0];
      #0.5;
      chk("R7 carrier follow", 32'(ledOut), 32'({3'b001, k[0]}));
      @(negedge clk);
    end
    carrierIn = 1'b0;
    wr(word(4'h1, 4'h0, 3'b000, 1'b0));
    chk("R7 carrier off", 32'(ledOut), 32'h1);

    // R8 all-ones write: only implemented bits read back, stored not live
    wr(32'h0);
    wr(32'hFFFF_FFFF);
    chk("R8 mask", rdData, 32'h07FF_2000);
    chk("R7/R8 lamps vs stored", 32'(ledOut), 32'hE);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule